// File: doc/BRIEF.md
# Hysteretic Debounced Current Detector

This block converts a stream of signed current measurements into a clean, debounced two-state detection flag. It also raises a sticky change interrupt. One copy watches the differential loop current and reports whether the line has gone off-hook. A second, identical copy watches the longitudinal current and reports a ground-key condition. New measurements arrive on a single-cycle valid strobe, at a rate of at least 2 kHz. Clock cycles that carry no strobe leave the detector untouched.

Two programmable thresholds provide hysteresis. While the flag is clear, a sample must lie strictly above the upper (set) threshold to count toward detection. While the flag is set, a sample must lie strictly below the lower (clear) threshold to count toward release. A run-length filter changes the flag only after enough consecutive counting samples have been seen. Every change of the flag latches an event bit. Software clears that bit by writing a one. The bit drives the interrupt line only while the interrupt is enabled.

Top module: `hyst_detector`

## Requirements
- R1: While rstN is low, and directly after it, detected, eventFlag and irq are all 0.
- R2: While detected is 0, a valid sample counts toward detection only if it is strictly greater than setLevel. The comparison treats both values as two's-complement signed numbers.
- R3: While detected is 1, a valid sample counts toward release only if it is strictly less than clearLevel, using a signed comparison. Samples at or between the thresholds never change the flag.
- R4: With filter length L (input runLen), the flag inverts on the (L+1)-th consecutive counting sample.
- R5: A valid sample that does not count toward the pending change resets the run to zero.
- R6: With runLen equal to 0, the first counting sample inverts the flag.
- R7: Cycles with sampleValid low do not change the flag. They also leave the run count as it was, whatever the value on sampleValue.
- R8: The flag changes on the same clock edge that accepts the deciding sample. It is visible one cycle after that sample is presented.
- R9: eventFlag is set on the edge where detected rises and on the edge where it falls. Once set, it stays set.
- R10: A high eventClear clears eventFlag at the next edge. If a flag change happens on that same edge, eventFlag stays at 1.
- R11: irq equals eventFlag AND irqEnable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | One-cycle strobe marking a new measurement |
| sampleValue | input | SAMPLE_W | Signed current measurement |
| setLevel | input | SAMPLE_W | Signed upper threshold for detection |
| clearLevel | input | SAMPLE_W | Signed lower threshold for release |
| runLen | input | CNT_W | Filter length L; the flag inverts on the (L+1)-th consecutive counting sample |
| irqEnable | input | 1 | Lets eventFlag reach irq |
| eventClear | input | 1 | Write-one-to-clear for eventFlag |
| detected | output | 1 | Debounced detection status |
| eventFlag | output | 1 | Sticky status-change flag |
| irq | output | 1 | Masked interrupt |

## Verification
The embedded properties check four things on every cycle. The flag moves only on a strobe cycle. A rise is always preceded by a sample above the set threshold, and a fall by a sample below the clear threshold. Each flag change leaves the event bit set. The event bit only drops after a clear request. What a property cannot show is the exact sample that decides a change. The bench scenarios cover this: run restarts by in-band samples, equality with each threshold, negative values, skipped strobes in the middle of a run, the zero-length filter, and the collision between a clear request and a new event.

// File: rtl/hyst_det_pkg.sv
package hyst_det_pkg;
  typedef struct packed {
    logic runClr;
    logic runInc;
    logic flip;
  } detStrobes_t;
endpackage

// File: rtl/hyst_det_datapath.sv
module hyst_det_datapath
  import hyst_det_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int CNT_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  detStrobes_t                strobes,
  input  logic signed [SAMPLE_W-1:0] sampleValue,
  input  logic signed [SAMPLE_W-1:0] setLevel,
  input  logic signed [SAMPLE_W-1:0] clearLevel,
  input  logic        [CNT_W-1:0]    runLen,
  output logic                       qualify,
  output logic                       atLimit,
  output logic                       detected
);
  localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] runCount;
  logic aboveSet;
  logic belowClear;

  always_comb begin
    aboveSet   = sampleValue > setLevel;
    belowClear = sampleValue < clearLevel;
    qualify    = detected ? belowClear : aboveSet;
    atLimit    = runCount >= runLen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCount <= '0;
    end else if (strobes.runClr) begin
      runCount <= '0;
    end else if (strobes.runInc && runCount != RUN_MAX) begin
      runCount <= runCount + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      detected <= 1'b0;
    end else if (strobes.flip) begin
      detected <= ~detected;
    end
  end

  // R2
  rise_needs_above_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(detected) |-> ($past(sampleValue) > $past(setLevel)));

  // R3
  fall_needs_below_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(detected) |-> ($past(sampleValue) < $past(clearLevel)));
endmodule

// File: rtl/hyst_det_control.sv
module hyst_det_control
  import hyst_det_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleValid,
  input  logic        qualify,
  input  logic        atLimit,
  input  logic        eventClear,
  output detStrobes_t strobes,
  output logic        eventFlag
);
  always_comb begin
    strobes = '0;
    if (sampleValid) begin
      if (!qualify) begin
        strobes.runClr = 1'b1;
      end else if (atLimit) begin
        strobes.flip   = 1'b1;
        strobes.runClr = 1'b1;
      end else begin
        strobes.runInc = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eventFlag <= 1'b0;
    end else if (strobes.flip) begin
      eventFlag <= 1'b1;
    end else if (eventClear) begin
      eventFlag <= 1'b0;
    end
  end

  // R10
  flag_drop_needs_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eventFlag) |-> $past(eventClear));
endmodule

// File: rtl/hyst_detector.sv
module hyst_detector
  import hyst_det_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int CNT_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] sampleValue,
  input  logic signed [SAMPLE_W-1:0] setLevel,
  input  logic signed [SAMPLE_W-1:0] clearLevel,
  input  logic        [CNT_W-1:0]    runLen,
  input  logic                       irqEnable,
  input  logic                       eventClear,
  output logic                       detected,
  output logic                       eventFlag,
  output logic                       irq
);
  detStrobes_t strobes;
  logic qualify;
  logic atLimit;

  hyst_det_datapath #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sampleValue(sampleValue),
    .setLevel(setLevel), .clearLevel(clearLevel), .runLen(runLen),
    .qualify(qualify), .atLimit(atLimit), .detected(detected)
  );

  hyst_det_control u_control (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .qualify(qualify),
    .atLimit(atLimit), .eventClear(eventClear), .strobes(strobes),
    .eventFlag(eventFlag)
  );

  assign irq = eventFlag & irqEnable;

  // R7
  change_only_on_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    (detected != $past(detected)) |-> $past(sampleValid));

  // R9
  change_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (detected != $past(detected)) |-> eventFlag);
endmodule

// File: tb/hyst_detector_bench.sv
module hyst_detector_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic signed [15:0] sampleValue = '0;
  logic signed [15:0] setLevel = 16'sd100;
  logic signed [15:0] clearLevel = 16'sd40;
  logic [7:0] runLen = 8'd2;
  logic irqEnable = 1'b0;
  logic eventClear = 1'b0;
  logic detected, eventFlag, irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  hyst_detector u_hyst_detector (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleValue(sampleValue),
    .setLevel(setLevel), .clearLevel(clearLevel), .runLen(runLen),
    .irqEnable(irqEnable), .eventClear(eventClear), .detected(detected),
    .eventFlag(eventFlag), .irq(irq)
  );

  // {valid, value, expected detected, expected eventFlag}; set=100 clear=40 runLen=2
  localparam int NVEC = 15;
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b1, 16'd150,  1'b0, 1'b0},
    {1'b1, 16'd150,  1'b0, 1'b0},
    {1'b1, 16'd70,   1'b0, 1'b0},
    {1'b1, 16'd120,  1'b0, 1'b0},
    {1'b1, 16'd120,  1'b0, 1'b0},
    {1'b1, 16'd101,  1'b1, 1'b1},
    {1'b1, 16'd30,   1'b1, 1'b1},
    {1'b1, 16'd40,   1'b1, 1'b1},
    {1'b1, 16'd10,   1'b1, 1'b1},
    {1'b0, 16'd500,  1'b1, 1'b1},
    {1'b1, 16'hFFFB, 1'b1, 1'b1},
    {1'b1, 16'd10,   1'b0, 1'b1},
    {1'b1, 16'd100,  1'b0, 1'b1},
    {1'b1, 16'd100,  1'b0, 1'b1},
    {1'b1, 16'd100,  1'b0, 1'b1}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic signed [15:0] val);
    @(negedge clk);
    sampleValid = v;
    sampleValue = val;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 detected in reset", detected, 1'b0);
    check("R1 eventFlag in reset", eventFlag, 1'b0);
    check("R1 irq in reset", irq, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 detected after reset", detected, 1'b0);

    // R2 R3 R4 R5 R7 R8 R9: vector walk
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][18], VEC[i][17:2]);
      check($sformatf("R4 R8 vector %0d detected", i), detected, VEC[i][1]);
      check($sformatf("R9 vector %0d eventFlag", i), eventFlag, VEC[i][0]);
    end

    // R11: masked then unmasked
    check("R11 irq masked", irq, 1'b0);
    irqEnable = 1'b1;
    #1;
    check("R11 irq enabled", irq, 1'b1);

    // R10: write-one-to-clear
    @(negedge clk);
    eventClear = 1'b1;
    @(negedge clk);
    eventClear = 1'b0;
    check("R10 eventFlag cleared", eventFlag, 1'b0);
    check("R11 irq after clear", irq, 1'b0);

    // R6 + R10 collision: runLen 0, clear request on the deciding edge
    runLen = 8'd0;
    @(negedge clk);
    sampleValid = 1'b1;
    sampleValue = 16'sd200;
    eventClear = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    eventClear = 1'b0;
    check("R6 single sample sets", detected, 1'b1);
    check("R10 set wins over clear", eventFlag, 1'b1);

    // R6 with negative release sample
    step(1'b1, -16'sd100);
    check("R6 single sample releases", detected, 1'b0);
    check("R9 flag after release", eventFlag, 1'b1);

    // R1: reset mid-run
    rstN = 1'b0;
    @(negedge clk);
    check("R1 detected on reset", detected, 1'b0);
    check("R1 eventFlag on reset", eventFlag, 1'b0);
    rstN = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule